// File: doc/BRIEF.md
# Post-Modify Address Generation Unit

This block produces every memory address a signal-processing core needs in one processor cycle. A processor cycle is split into four slots, and one shared address bus carries them in a fixed order: the instruction fetch, the coefficient fetch, the data read and the data write. In each slot the unit places the current value of the chosen pointer register on the bus. On the clock edge that ends the slot, it adjusts that register and writes it back, so a later slot in the same processor cycle sees the adjusted value.

The unit holds seven registers:

- a program counter;
- a single-level return register;
- two general pointers, X and Y;
- two step registers, S0 and S1;
- a loop counter.

The program counter only ever steps by one. The pointers step by zero, plus one, minus one, or the contents of either step register, and the instruction picks which. Any register can be loaded from the decoder, either unconditionally or only when an external condition holds. Call, return and decrement-and-branch are applied on the last slot edge of the processor cycle. A flag reports when the loop counter is zero.

The instruction decoder holds all control inputs stable for the four slots of a processor cycle. The memories themselves are outside this block.

Top module: `addr_gen_unit`

## Requirements
- R1: A synchronous active-low reset clears all seven registers and the slot counter. After reset the bus shows slot 0 with address 0, and `lc_zero` is 1.
- R2: `addr_slot` counts 0 (instruction), 1 (coefficient), 2 (data read), 3 (data write) and then repeats. Slot 0 is always valid and shows the program counter. The program counter grows by exactly 1 at the end of slot 0, and it changes at no other slot except by rule R3, R8, R9 or R10.
- R3: The coefficient slot shows X when `coef_use_x`=1. When `coef_use_x`=0 it shows the program counter, which then steps by +1 whatever `coef_mod` holds.
- R4: The bus shows the register value from before the step. Step codes are 0: +0, 1: +1, 2: -1, 3: +S0, 4: +S1. Codes 5 to 7 act as +0. A later slot in the same processor cycle sees the stepped value.
- R5: All register arithmetic wraps modulo 2^AW (1024 by default), so 1023+1 gives 0.
- R6: The data slots use Y when `*_use_x`=0 and X when it is 1. A slot whose enable is low drives `addr_vld`=0 and a bus of zero, and it changes no register.
- R7: Loads take effect at the end of slot 3. `ld_sel` codes are 0 program counter, 1 return, 2 X, 3 Y, 4 S0, 5 S1, 6 loop counter. When `ld_if_cond`=1, the load happens only if `cond_in`=1.
- R8: When a register is both loaded and stepped, or loaded and changed by flow control, in the same processor cycle, the loaded value wins.
- R9: `flow_op` 1 (call) copies the program counter into the return register and jumps to `flow_tgt`. `flow_op` 2 (return) copies the return register into the program counter.
- R10: `flow_op` 3 decrements the loop counter. It jumps to `flow_tgt` if the decremented value is nonzero, and otherwise the program counter keeps its stepped value.
- R11: `lc_zero` is 1 exactly when the loop counter holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, four per processor cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_en | input | 1 | Coefficient slot is used |
| coef_use_x | input | 1 | Coefficient pointer: 0 program counter, 1 X |
| coef_mod | input | 3 | Step code for the coefficient pointer |
| rd_en | input | 1 | Data-read slot is used |
| rd_use_x | input | 1 | Data-read pointer: 0 Y, 1 X |
| rd_mod | input | 3 | Step code for the data-read pointer |
| wr_en | input | 1 | Data-write slot is used |
| wr_use_x | input | 1 | Data-write pointer: 0 Y, 1 X |
| wr_mod | input | 3 | Step code for the data-write pointer |
| ld_en | input | 1 | Load request |
| ld_if_cond | input | 1 | Load only when `cond_in` is high |
| cond_in | input | 1 | Condition for conditional loads |
| ld_sel | input | 3 | Register to load |
| ld_val | input | AW | Value to load |
| flow_op | input | 2 | 0 none, 1 call, 2 return, 3 decrement-and-branch |
| flow_tgt | input | AW | Jump target |
| addr_bus | output | AW | Shared address bus |
| addr_vld | output | 1 | Current slot carries a reference |
| addr_slot | output | 2 | Current slot number |
| lc_zero | output | 1 | Loop counter is zero |

## Verification
The bench walks the pointers through every step code, with the two step registers holding +5 and -3. This separates a wrong adder input, a wrong sign and a missing wrap. Some processor cycles use X in two or three slots. Those show whether each slot sees the previous slot's written-back value rather than the value at the start of the cycle. Other patterns collide a load with a step, and a load with a call, to tell load priority apart from step or branch priority. A three-pass decrement-and-branch loop, followed by a return, separates the branch-taken and fall-through paths and the return address that was saved.

// File: rtl/agu_pkg.sv
// Shared encodings for the address generation unit.
// Assumes: the decoder drives these codes directly on the top-level ports.
package agu_pkg;

    typedef enum logic [1:0] {
        SLOT_INSTR = 2'd0,
        SLOT_COEF  = 2'd1,
        SLOT_RD    = 2'd2,
        SLOT_WR    = 2'd3
    } slot_e;

    typedef enum logic [2:0] {
        STEP_ZERO = 3'd0,
        STEP_INC  = 3'd1,
        STEP_DEC  = 3'd2,
        STEP_S0   = 3'd3,
        STEP_S1   = 3'd4
    } step_e;

    typedef enum logic [2:0] {
        REG_PC   = 3'd0,
        REG_RET  = 3'd1,
        REG_X    = 3'd2,
        REG_Y    = 3'd3,
        REG_S0   = 3'd4,
        REG_S1   = 3'd5,
        REG_LC   = 3'd6,
        REG_NONE = 3'd7
    } reg_e;

    typedef enum logic [1:0] {
        FLOW_NONE = 2'd0,
        FLOW_CALL = 2'd1,
        FLOW_RET  = 2'd2,
        FLOW_DJNZ = 2'd3
    } flow_e;

endpackage

// File: rtl/agu_slot_seq.sv
// Slot sequencer: counts the four address slots of one processor cycle.
// Assumes: one clock per slot; the count wraps after the data-write slot.
module agu_slot_seq
    import agu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);

    // Advance to the next slot on every clock; reset returns to the instruction slot.
    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SLOT_INSTR;
        else        slot <= slot_e'(slot + 2'd1);
    end

    // R2: the slots follow the fixed order and wrap from 3 to 0.
    a_r2_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (slot == slot_e'($past(slot) + 2'd1)));

endmodule

// File: rtl/agu_modifier.sv
// Address adder: computes the post-modified value of one pointer.
// Assumes: codes 5 to 7 are reserved and step by zero; sums wrap at AW bits.
module agu_modifier
    import agu_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0] base,
    input  step_e         code,
    input  logic [AW-1:0] step0,
    input  logic [AW-1:0] step1,
    output logic [AW-1:0] next
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] delta;

    // Select the addend from the step code.
    always_comb begin
        case (code)
            STEP_INC: delta = ONE;
            STEP_DEC: delta = '1;
            STEP_S0:  delta = step0;
            STEP_S1:  delta = step1;
            default:  delta = '0;
        endcase
    end

    // Add modulo 2^AW.
    always_comb next = base + delta;

endmodule

// File: rtl/agu_regs.sv
// Register file of the address unit: program counter, return register,
// pointers X and Y, step registers S0 and S1, and the loop counter.
// Assumes: loads and flow control are applied on the edge ending the
// data-write slot; a load wins over stepping and over flow control.
module agu_regs
    import agu_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         slot,
    input  logic          step_hit,
    input  reg_e          step_reg,
    input  logic [AW-1:0] step_next,
    input  logic          ld_en,
    input  logic          ld_if_cond,
    input  logic          cond_in,
    input  reg_e          ld_sel,
    input  logic [AW-1:0] ld_val,
    input  flow_e         flow_op,
    input  logic [AW-1:0] flow_tgt,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] ret_q,
    output logic [AW-1:0] x_q,
    output logic [AW-1:0] y_q,
    output logic [AW-1:0] s0_q,
    output logic [AW-1:0] s1_q,
    output logic [AW-1:0] lc_q
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic          commit;
    logic          ld_go;
    logic [AW-1:0] lc_dec;

    // Qualify the end-of-cycle edge, the load and the loop decrement.
    always_comb begin
        commit = (slot == SLOT_WR);
        ld_go  = commit && ld_en && (!ld_if_cond || cond_in);
        lc_dec = lc_q - ONE;
    end

    // Program counter: load, then flow control, then the +1 step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (ld_go && ld_sel == REG_PC)
            pc_q <= ld_val;
        else if (commit && flow_op == FLOW_CALL)
            pc_q <= flow_tgt;
        else if (commit && flow_op == FLOW_RET)
            pc_q <= ret_q;
        else if (commit && flow_op == FLOW_DJNZ && lc_dec != '0)
            pc_q <= flow_tgt;
        else if (step_hit && step_reg == REG_PC)
            pc_q <= step_next;
    end

    // Return register: load, else capture the stepped program counter on a call.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ret_q <= '0;
        else if (ld_go && ld_sel == REG_RET)
            ret_q <= ld_val;
        else if (commit && flow_op == FLOW_CALL)
            ret_q <= pc_q;
    end

    // Pointer X: load has priority over the post-modify write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            x_q <= '0;
        else if (ld_go && ld_sel == REG_X)
            x_q <= ld_val;
        else if (step_hit && step_reg == REG_X)
            x_q <= step_next;
    end

    // Pointer Y: load has priority over the post-modify write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_q <= '0;
        else if (ld_go && ld_sel == REG_Y)
            y_q <= ld_val;
        else if (step_hit && step_reg == REG_Y)
            y_q <= step_next;
    end

    // Step registers: changed only by loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q <= '0;
            s1_q <= '0;
        end else begin
            if (ld_go && ld_sel == REG_S0) s0_q <= ld_val;
            if (ld_go && ld_sel == REG_S1) s1_q <= ld_val;
        end
    end

    // Loop counter: load, else decrement on decrement-and-branch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lc_q <= '0;
        else if (ld_go && ld_sel == REG_LC)
            lc_q <= ld_val;
        else if (commit && flow_op == FLOW_DJNZ)
            lc_q <= lc_dec;
    end

    // R2: outside the end-of-cycle edge the program counter holds or steps by one.
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != SLOT_WR) |=> (pc_q == $past(pc_q) || pc_q == $past(pc_q) + ONE));

    // R8: a load of X wins over any step of X in the same edge.
    a_r8_load_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_WR && ld_en && (!ld_if_cond || cond_in) && ld_sel == REG_X)
        |=> (x_q == $past(ld_val)));

    // R9: a return restores the saved address unless the program counter is loaded.
    a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_WR && flow_op == FLOW_RET && !(ld_en && ld_sel == REG_PC))
        |=> (pc_q == $past(ret_q)));

    // R10: decrement-and-branch lowers the loop counter by one.
    a_r10_djnz_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_WR && flow_op == FLOW_DJNZ && !(ld_en && ld_sel == REG_LC))
        |=> (lc_q == $past(lc_q) - ONE));

endmodule

// File: rtl/addr_gen_unit.sv
// Address generation unit top: time-multiplexes four references per
// processor cycle onto one address bus and post-modifies each pointer.
// Assumes: decoder inputs are held stable over the four slots of a cycle.
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_en,
    input  logic          coef_use_x,
    input  logic [2:0]    coef_mod,
    input  logic          rd_en,
    input  logic          rd_use_x,
    input  logic [2:0]    rd_mod,
    input  logic          wr_en,
    input  logic          wr_use_x,
    input  logic [2:0]    wr_mod,
    input  logic          ld_en,
    input  logic          ld_if_cond,
    input  logic          cond_in,
    input  logic [2:0]    ld_sel,
    input  logic [AW-1:0] ld_val,
    input  logic [1:0]    flow_op,
    input  logic [AW-1:0] flow_tgt,
    output logic [AW-1:0] addr_bus,
    output logic          addr_vld,
    output logic [1:0]    addr_slot,
    output logic          lc_zero
);

    slot_e         slot;
    logic          hit;
    reg_e          sel_reg;
    step_e         code;
    logic [AW-1:0] base;
    logic [AW-1:0] stepped;
    logic [AW-1:0] pc_q, ret_q, x_q, y_q, s0_q, s1_q, lc_q;

    agu_slot_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    // Decode which register the current slot uses and how it steps.
    always_comb begin
        case (slot)
            SLOT_INSTR: begin
                hit     = 1'b1;
                sel_reg = REG_PC;
                code    = STEP_INC;
            end
            SLOT_COEF: begin
                hit     = coef_en;
                sel_reg = coef_use_x ? REG_X : REG_PC;
                code    = coef_use_x ? step_e'(coef_mod) : STEP_INC;
            end
            SLOT_RD: begin
                hit     = rd_en;
                sel_reg = rd_use_x ? REG_X : REG_Y;
                code    = step_e'(rd_mod);
            end
            default: begin
                hit     = wr_en;
                sel_reg = wr_use_x ? REG_X : REG_Y;
                code    = step_e'(wr_mod);
            end
        endcase
    end

    // Pick the current value of the selected pointer.
    always_comb begin
        case (sel_reg)
            REG_X:   base = x_q;
            REG_Y:   base = y_q;
            default: base = pc_q;
        endcase
    end

    agu_modifier #(.AW(AW)) u_mod (
        .base  (base),
        .code  (code),
        .step0 (s0_q),
        .step1 (s1_q),
        .next  (stepped)
    );

    agu_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .step_hit   (hit),
        .step_reg   (sel_reg),
        .step_next  (stepped),
        .ld_en      (ld_en),
        .ld_if_cond (ld_if_cond),
        .cond_in    (cond_in),
        .ld_sel     (reg_e'(ld_sel)),
        .ld_val     (ld_val),
        .flow_op    (flow_e'(flow_op)),
        .flow_tgt   (flow_tgt),
        .pc_q       (pc_q),
        .ret_q      (ret_q),
        .x_q        (x_q),
        .y_q        (y_q),
        .s0_q       (s0_q),
        .s1_q       (s1_q),
        .lc_q       (lc_q)
    );

    // Drive the shared bus with the pre-modify value; idle slots drive zero.
    always_comb begin
        addr_bus  = hit ? base : '0;
        addr_vld  = hit;
        addr_slot = slot;
        lc_zero   = (lc_q == '0);
    end

    // R6: an unused data-read slot leaves both pointers unchanged.
    a_r6_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_RD && !rd_en) |=> (x_q == $past(x_q) && y_q == $past(y_q)));

    // R2: the instruction slot always carries a reference.
    a_r2_instr_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_slot == 2'd0) |-> addr_vld);

endmodule

// File: tb/sim_addr_gen_unit.sv
module sim_addr_gen_unit;

    localparam int AW = 10;
    localparam int NV = 19;

    typedef struct packed {
        logic       coef_en;
        logic       coef_x;
        logic [2:0] coef_mod;
        logic       rd_en;
        logic       rd_x;
        logic [2:0] rd_mod;
        logic       wr_en;
        logic       wr_x;
        logic [2:0] wr_mod;
        logic       ld_en;
        logic       ld_c;
        logic       cond;
        logic [2:0] ld_sel;
        logic [9:0] ld_val;
        logic [1:0] flow;
        logic [9:0] tgt;
        logic [2:0] evld;
        logic [9:0] e0;
        logic [9:0] e1;
        logic [9:0] e2;
        logic [9:0] e3;
        logic       elcz;
    } vec_t;

    // Each entry is one processor cycle: its inputs, then the expected bus for slots 0..3
    // (evld bit 2 = slot 1, bit 0 = slot 3), then lc_zero after the cycle ends.
    localparam vec_t VECS [NV] = '{
        '{0,0,0, 0,0,0, 0,0,0, 1,0,0, 3'd4, 10'd5,    2'd0, 10'd0,   3'b000, 10'd0,   10'd0,   10'd0,    10'd0,    1'b1},
        '{0,0,0, 0,0,0, 0,0,0, 1,0,0, 3'd5, 10'd1021, 2'd0, 10'd0,   3'b000, 10'd1,   10'd0,   10'd0,    10'd0,    1'b1},
        '{0,0,0, 0,0,0, 0,0,0, 1,0,0, 3'd2, 10'd100,  2'd0, 10'd0,   3'b000, 10'd2,   10'd0,   10'd0,    10'd0,    1'b1},
        '{0,0,0, 0,0,0, 0,0,0, 1,0,0, 3'd3, 10'd1020, 2'd0, 10'd0,   3'b000, 10'd3,   10'd0,   10'd0,    10'd0,    1'b1},
        '{1,1,3, 1,0,1, 1,0,1, 0,0,0, 3'd0, 10'd0,    2'd0, 10'd0,   3'b111, 10'd4,   10'd100, 10'd1020, 10'd1021, 1'b1},
        '{1,0,2, 1,1,2, 1,1,4, 0,0,0, 3'd0, 10'd0,    2'd0, 10'd0,   3'b111, 10'd5,   10'd6,   10'd105,  10'd104,  1'b1},
        '{0,0,0, 1,0,1, 1,0,1, 0,0,0, 3'd0, 10'd0,    2'd0, 10'd0,   3'b011, 10'd7,   10'd0,   10'd1022, 10'd1023, 1'b1},
        '{1,1,5, 1,1,0, 0,0,0, 1,1,0, 3'd2, 10'd500,  2'd0, 10'd0,   3'b110, 10'd8,   10'd101, 10'd101,  10'd0,    1'b1},
        '{1,1,1, 1,1,1, 1,1,1, 1,1,1, 3'd2, 10'd500,  2'd0, 10'd0,   3'b111, 10'd9,   10'd101, 10'd102,  10'd103,  1'b1},
        '{1,1,0, 1,0,0, 0,0,0, 1,0,0, 3'd6, 10'd3,    2'd0, 10'd0,   3'b110, 10'd10,  10'd500, 10'd0,    10'd0,    1'b0},
        '{0,0,0, 0,0,0, 0,0,0, 0,0,0, 3'd0, 10'd0,    2'd1, 10'd200, 3'b000, 10'd11,  10'd0,   10'd0,    10'd0,    1'b0},
        '{0,0,0, 0,0,0, 0,0,0, 0,0,0, 3'd0, 10'd0,    2'd3, 10'd300, 3'b000, 10'd200, 10'd0,   10'd0,    10'd0,    1'b0},
        '{0,0,0, 0,0,0, 0,0,0, 0,0,0, 3'd0, 10'd0,    2'd3, 10'd300, 3'b000, 10'd300, 10'd0,   10'd0,    10'd0,    1'b0},
        '{0,0,0, 0,0,0, 0,0,0, 0,0,0, 3'd0, 10'd0,    2'd3, 10'd300, 3'b000, 10'd300, 10'd0,   10'd0,    10'd0,    1'b1},
        '{0,0,0, 0,0,0, 0,0,0, 0,0,0, 3'd0, 10'd0,    2'd2, 10'd0,   3'b000, 10'd301, 10'd0,   10'd0,    10'd0,    1'b1},
        '{0,0,0, 0,0,0, 0,0,0, 1,0,0, 3'd0, 10'd40,   2'd1, 10'd700, 3'b000, 10'd12,  10'd0,   10'd0,    10'd0,    1'b1},
        '{0,0,0, 0,0,0, 0,0,0, 0,0,0, 3'd0, 10'd0,    2'd2, 10'd0,   3'b000, 10'd40,  10'd0,   10'd0,    10'd0,    1'b1},
        '{0,0,0, 1,0,3, 1,0,1, 1,0,0, 3'd3, 10'd7,    2'd0, 10'd0,   3'b011, 10'd13,  10'd0,   10'd0,    10'd5,    1'b1},
        '{0,0,0, 1,0,0, 0,0,0, 0,0,0, 3'd0, 10'd0,    2'd0, 10'd0,   3'b010, 10'd14,  10'd0,   10'd7,    10'd0,    1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_en, coef_use_x, rd_en, rd_use_x, wr_en, wr_use_x;
    logic [2:0]    coef_mod, rd_mod, wr_mod, ld_sel;
    logic          ld_en, ld_if_cond, cond_in;
    logic [AW-1:0] ld_val, flow_tgt;
    logic [1:0]    flow_op;
    logic [AW-1:0] addr_bus;
    logic          addr_vld;
    logic [1:0]    addr_slot;
    logic          lc_zero;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    addr_gen_unit #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .coef_en(coef_en), .coef_use_x(coef_use_x), .coef_mod(coef_mod),
        .rd_en(rd_en), .rd_use_x(rd_use_x), .rd_mod(rd_mod),
        .wr_en(wr_en), .wr_use_x(wr_use_x), .wr_mod(wr_mod),
        .ld_en(ld_en), .ld_if_cond(ld_if_cond), .cond_in(cond_in),
        .ld_sel(ld_sel), .ld_val(ld_val), .flow_op(flow_op), .flow_tgt(flow_tgt),
        .addr_bus(addr_bus), .addr_vld(addr_vld), .addr_slot(addr_slot), .lc_zero(lc_zero)
    );

    function automatic string vec_tag(int i);
        case (i)
            0, 2, 3, 7: return "R7";
            1:          return "R6";
            4:          return "R4";
            5:          return "R3";
            6:          return "R5";
            8, 9, 15, 17, 18: return "R8";
            10, 14, 16: return "R9";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        coef_en = v.coef_en; coef_use_x = v.coef_x; coef_mod = v.coef_mod;
        rd_en = v.rd_en; rd_use_x = v.rd_x; rd_mod = v.rd_mod;
        wr_en = v.wr_en; wr_use_x = v.wr_x; wr_mod = v.wr_mod;
        ld_en = v.ld_en; ld_if_cond = v.ld_c; cond_in = v.cond;
        ld_sel = v.ld_sel; ld_val = v.ld_val; flow_op = v.flow; flow_tgt = v.tgt;
    endtask

    task automatic idle();
        drive('0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state right after reset.
        check("R1", "slot after reset", addr_slot, 0);
        check("R1", "pc after reset", addr_bus, 0);
        check("R1", "lc_zero after reset", lc_zero, 1);

        for (int i = 0; i < NV; i++) begin
            logic [9:0] exp_a [4];
            logic       exp_v [4];
            drive(VECS[i]);
            exp_a[0] = VECS[i].e0; exp_a[1] = VECS[i].e1;
            exp_a[2] = VECS[i].e2; exp_a[3] = VECS[i].e3;
            exp_v[0] = 1'b1; exp_v[1] = VECS[i].evld[2];
            exp_v[2] = VECS[i].evld[1]; exp_v[3] = VECS[i].evld[0];
            for (int s = 0; s < 4; s++) begin
                #1;
                check(vec_tag(i), $sformatf("vec %0d slot %0d valid", i, s), addr_vld, exp_v[s]);
                check(vec_tag(i), $sformatf("vec %0d slot %0d addr", i, s), addr_bus, exp_a[s]);
                @(negedge clk);
            end
            #1;
            check("R11", $sformatf("vec %0d lc_zero", i), lc_zero, VECS[i].elcz);
        end

        // R2: slot numbering over one processor cycle.
        idle();
        for (int s = 0; s < 4; s++) begin
            #1;
            check("R2", "slot order", addr_slot, s);
            @(negedge clk);
        end

        // R1: a reset in mid-run clears the pointers and the program counter.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        coef_en = 1'b1; coef_use_x = 1'b1; coef_mod = 3'd0;
        #1;
        check("R1", "slot after mid reset", addr_slot, 0);
        check("R1", "pc after mid reset", addr_bus, 0);
        check("R1", "lc_zero after mid reset", lc_zero, 1);
        @(negedge clk);
        #1;
        check("R1", "X after mid reset", addr_bus, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule